// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

This block rotates a signed two-dimensional vector by a commanded angle. A new vector and angle may enter on every enabled clock. The rotated vector appears a fixed number of enabled cycles later. The angle is an unsigned phase word in which a full turn is 2^PW. Increasing phase turns the vector counterclockwise. The output carries the usual CORDIC magnitude growth: no gain correction is applied, so a downstream block must scale the result if it needs unity gain.

Each input coordinate is first widened to a working width WW. Two guard bits sit above it and zero fraction bits sit below it. A coarse rotation by a multiple of a right angle brings the residual angle within one eighth of a turn. A chain of shift-and-add micro-rotation stages then drives that residual toward zero. A stage whose shift would exceed the working width, or whose angle quantizes to zero, only registers its inputs. A rounding register reduces the result to OW bits. A single side-band bit travels through a delay line of the same length as the data path. It marks which output samples are meaningful. A clock enable stalls everything, and a synchronous reset empties everything.

Top module: `cordic_rotator`

## Requirements
- R1: With scale S = 2^(OW-IW-2), phase angle t = 2*pi*phase/2^PW and G = product of sqrt(1+4^-n) over the active stages n = k+1, each output lies within 1.5 LSB of S*G*(x*cos t - y*sin t) and S*G*(x*sin t + y*cos t). With the default parameters G is about 1.1644 and S is 1.
- R2: The three most significant phase bits pick a coarse turn of the widened vector. Codes 000 and 111 pick no turn. Codes 001 and 010 pick +90 degrees, mapping (x,y) to (-y,x), and subtract 2^(PW-2) from the phase. Codes 011 and 100 pick 180 degrees and subtract 2^(PW-1). Codes 101 and 110 pick 270 degrees, mapping (x,y) to (y,-x), and subtract 3*2^(PW-2). The residual, read as signed, then lies within plus or minus 2^(PW-3).
- R3: Stage k shifts each coordinate arithmetically right by k+1 bits. When the residual is non-negative, the stage turns the vector counterclockwise and subtracts its angle. When the residual is negative, it turns the vector the other way and adds the angle.
- R4: The angle of stage k is atan(2^-(k+1)) expressed in phase units (2^PW per turn) and rounded to the nearest unit.
- R5: A stage with k+1 >= WW, or whose angle rounds to zero, passes x, y and the residual through one register unchanged. Such a stage adds no gain. With PW = 16 and 16 stages, the last two stages behave this way.
- R6: The final working-width values are reduced to OW bits by adding 2^(WW-OW-1) and keeping the top OW bits, which rounds to nearest.
- R7: The side-band bit appears on aux_out exactly NSTAGES+2 enabled cycles after it enters. It is high exactly for the output samples whose inputs entered with it high.
- R8: While ce is low, no register changes. x_out, y_out and aux_out hold their values.
- R9: A synchronous reset clears x_out, y_out, aux_out and every pipeline register, including the side-band delay line, even while ce is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for every register |
| x_in | input | IW | Signed input x coordinate |
| y_in | input | IW | Signed input y coordinate |
| phase_in | input | PW | Rotation angle, 2^PW per full turn |
| aux_in | input | 1 | Side-band marker for the entering sample |
| x_out | output | OW | Signed rotated x coordinate |
| y_out | output | OW | Signed rotated y coordinate |
| aux_out | output | 1 | Side-band marker aligned with the output sample |

## Verification
Two functions can meet in the same clock edge: a stall caused by ce going low, and either a synchronous reset or the pipeline carrying live marked samples. The bench drops ce on a fixed cadence while marked and unmarked samples stream through. At each stalled edge it checks that the outputs hold. It also checks that every marked sample still comes out in order and within tolerance once the pipeline resumes. In a separate step, reset is raised while ce is low and the pipeline is full of marked samples. The bench then requires zero outputs at once and no marker emerging over the following full latency.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

   // Angle atan(2^-n) as a fraction of one turn, scaled by 2^32 (n >= 1).
   function automatic logic [63:0] turn_frac32(input int n);
      logic [63:0] v;
      case (n)
         1:       v = 64'd316933406;
         2:       v = 64'd167458908;
         3:       v = 64'd85004757;
         4:       v = 64'd42667331;
         5:       v = 64'd21354465;
         6:       v = 64'd10679849;
         7:       v = 64'd5340245;
         8:       v = 64'd2670163;
         9:       v = 64'd1335087;
         default: v = 64'd683565276 >> n; // atan(t) ~ t for small t
      endcase
      return v;
   endfunction

   // Elementary angle of stage n in PW-bit phase units, rounded to nearest.
   function automatic logic [31:0] elem_angle(input int n, input int pw);
      logic [63:0] v;
      logic [63:0] r;
      v = turn_frac32(n);
      if (pw >= 32) r = v;
      else          r = (v + (64'd1 << (31 - pw))) >> (32 - pw);
      return r[31:0];
   endfunction

   // Stage k (0-based) is a registered pass-through when ineffective.
   function automatic bit stage_bypass(input int k, input int ww, input int pw);
      return (k + 1 >= ww) || (elem_angle(k + 1, pw) == 32'd0);
   endfunction

endpackage

// File: rtl/cordic_rot_prerot.sv
module cordic_rot_prerot #(
   parameter int IW = 12,
   parameter int WW = 20,
   parameter int PW = 20
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic signed [IW-1:0] x_i,
   input  logic signed [IW-1:0] y_i,
   input  logic [PW-1:0]        p_i,
   output logic signed [WW-1:0] x_o,
   output logic signed [WW-1:0] y_o,
   output logic [PW-1:0]        p_o
);
   localparam int FR = WW - IW - 2;
   localparam logic [PW-1:0] QTR  = PW'(1) << (PW - 2);
   localparam logic [PW-1:0] HALF = PW'(1) << (PW - 1);
   localparam logic [PW-1:0] TQTR = QTR + HALF;

   logic signed [WW-1:0] xe, ye, xr, yr;
   logic [PW-1:0]        pr;

   always_comb begin
      xe = WW'(x_i) <<< FR;
      ye = WW'(y_i) <<< FR;
      case (p_i[PW-1 -: 3])
         3'b001, 3'b010: begin xr = -ye; yr =  xe; pr = p_i - QTR;  end
         3'b011, 3'b100: begin xr = -xe; yr = -ye; pr = p_i - HALF; end
         3'b101, 3'b110: begin xr =  ye; yr = -xe; pr = p_i - TQTR; end
         default:        begin xr =  xe; yr =  ye; pr = p_i;        end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_o <= '0;
         y_o <= '0;
         p_o <= '0;
      end else if (ce) begin
         x_o <= xr;
         y_o <= yr;
         p_o <= pr;
      end
   end
endmodule

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage #(
   parameter int          WW     = 20,
   parameter int          PW     = 20,
   parameter int          SHIFT  = 1,
   parameter logic [31:0] ANGLE  = 32'd0,
   parameter bit          BYPASS = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic signed [WW-1:0] x_i,
   input  logic signed [WW-1:0] y_i,
   input  logic [PW-1:0]        p_i,
   output logic signed [WW-1:0] x_o,
   output logic signed [WW-1:0] y_o,
   output logic [PW-1:0]        p_o
);
   generate
      if (BYPASS) begin : g_pass
         always_ff @(posedge clk) begin
            if (rst) begin
               x_o <= '0;
               y_o <= '0;
               p_o <= '0;
            end else if (ce) begin
               x_o <= x_i;
               y_o <= y_i;
               p_o <= p_i;
            end
         end
      end else begin : g_rot
         localparam logic [PW-1:0] ANG = ANGLE[PW-1:0];
         logic signed [WW-1:0] xs, ys;
         logic                 neg;
         assign xs  = x_i >>> SHIFT;
         assign ys  = y_i >>> SHIFT;
         assign neg = p_i[PW-1];
         always_ff @(posedge clk) begin
            if (rst) begin
               x_o <= '0;
               y_o <= '0;
               p_o <= '0;
            end else if (ce) begin
               if (neg) begin
                  x_o <= x_i + ys;
                  y_o <= y_i - xs;
                  p_o <= p_i + ANG;
               end else begin
                  x_o <= x_i - ys;
                  y_o <= y_i + xs;
                  p_o <= p_i - ANG;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/cordic_rot_round.sv
module cordic_rot_round #(
   parameter int WW = 20,
   parameter int OW = 14
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic signed [WW-1:0] x_i,
   input  logic signed [WW-1:0] y_i,
   output logic signed [OW-1:0] x_o,
   output logic signed [OW-1:0] y_o
);
   logic signed [OW-1:0] xn, yn;

   generate
      if (WW > OW) begin : g_round
         localparam logic [WW:0] HALF_LSB = (WW + 1)'(1) << (WW - OW - 1);
         logic [WW:0] xs, ys;
         assign xs = {x_i[WW-1], x_i} + HALF_LSB;
         assign ys = {y_i[WW-1], y_i} + HALF_LSB;
         assign xn = xs[WW-1:WW-OW];
         assign yn = ys[WW-1:WW-OW];
      end else begin : g_same
         assign xn = x_i;
         assign yn = y_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         x_o <= '0;
         y_o <= '0;
      end else if (ce) begin
         x_o <= xn;
         y_o <= yn;
      end
   end
endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator #(
   parameter int IW      = 12,
   parameter int OW      = 14,
   parameter int WW      = 20,
   parameter int PW      = 20,
   parameter int NSTAGES = 16
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic signed [IW-1:0] x_in,
   input  logic signed [IW-1:0] y_in,
   input  logic [PW-1:0]        phase_in,
   input  logic                 aux_in,
   output logic signed [OW-1:0] x_out,
   output logic signed [OW-1:0] y_out,
   output logic                 aux_out
);
   localparam int LAT = NSTAGES + 2;

   // Elaboration-time parameter checks
   generate
      if (WW < IW + 2) begin : g_bad_ww
         $error("cordic_rotator: WW must leave two guard bits above IW");
      end
      if (OW > WW) begin : g_bad_ow
         $error("cordic_rotator: OW may not exceed WW");
      end
      if (PW < 4 || PW > 32) begin : g_bad_pw
         $error("cordic_rotator: PW must lie in 4..32");
      end
      if (NSTAGES < 1 || NSTAGES > 40) begin : g_bad_ns
         $error("cordic_rotator: NSTAGES must lie in 1..40");
      end
   endgenerate

   logic signed [WW-1:0] xp [0:NSTAGES];
   logic signed [WW-1:0] yp [0:NSTAGES];
   logic [PW-1:0]        pp [0:NSTAGES];
   logic [LAT-1:0]       aux_sr;

   cordic_rot_prerot #(.IW(IW), .WW(WW), .PW(PW)) u_prerot (
      .clk(clk), .rst(rst), .ce(ce),
      .x_i(x_in), .y_i(y_in), .p_i(phase_in),
      .x_o(xp[0]), .y_o(yp[0]), .p_o(pp[0])
   );

   generate
      for (genvar k = 0; k < NSTAGES; k++) begin : g_stage
         localparam logic [31:0] ANG_K = cordic_rot_pkg::elem_angle(k + 1, PW);
         localparam bit          BYP_K = cordic_rot_pkg::stage_bypass(k, WW, PW);
         cordic_rot_stage #(
            .WW(WW), .PW(PW), .SHIFT(k + 1), .ANGLE(ANG_K), .BYPASS(BYP_K)
         ) u_stage (
            .clk(clk), .rst(rst), .ce(ce),
            .x_i(xp[k]),   .y_i(yp[k]),   .p_i(pp[k]),
            .x_o(xp[k+1]), .y_o(yp[k+1]), .p_o(pp[k+1])
         );
      end
   endgenerate

   cordic_rot_round #(.WW(WW), .OW(OW)) u_round (
      .clk(clk), .rst(rst), .ce(ce),
      .x_i(xp[NSTAGES]), .y_i(yp[NSTAGES]),
      .x_o(x_out), .y_o(y_out)
   );

   always_ff @(posedge clk) begin
      if (rst)     aux_sr <= '0;
      else if (ce) aux_sr <= {aux_sr[LAT-2:0], aux_in};
   end

   assign aux_out = aux_sr[LAT-1];
endmodule

// File: rtl/cordic_rot_checker.sv
module cordic_rot_checker #(
   parameter int OW      = 14,
   parameter int WW      = 20,
   parameter int PW      = 20,
   parameter int NSTAGES = 16
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 ce,
   input logic                 aux_in,
   input logic                 aux_first,
   input logic                 aux_out,
   input logic signed [OW-1:0] x_out,
   input logic signed [OW-1:0] y_out,
   input logic [PW-1:0]        stage_ph [0:NSTAGES]
);
   localparam logic signed [PW-1:0] OCT = PW'(1) << (PW - 3);

   logic armed;
   always_ff @(posedge clk) begin
      if (rst) armed <= 1'b1;
   end

   // R2: residual after the coarse turn stays within one eighth of a turn
   a_r2_residual_octant: assert property (@(posedge clk) disable iff (rst || !armed)
      ($signed(stage_ph[0]) <= OCT) && ($signed(stage_ph[0]) >= -OCT));

   // R5: ineffective stages leave the residual phase untouched
   generate
      for (genvar k = 0; k < NSTAGES; k++) begin : g_byp
         if (cordic_rot_pkg::stage_bypass(k, WW, PW)) begin : g_on
            a_r5_bypass_phase: assert property (@(posedge clk) disable iff (rst || !armed)
               ce |=> stage_ph[k+1] == $past(stage_ph[k]));
         end
      end
   endgenerate

   // R7: the marker enters the delay line on every enabled edge
   a_r7_aux_entry: assert property (@(posedge clk) disable iff (rst || !armed)
      ce |=> aux_first == $past(aux_in));

   // R8: a disabled edge changes no output
   a_r8_hold_outputs: assert property (@(posedge clk) disable iff (rst || !armed)
      !ce |=> $stable(x_out) && $stable(y_out) && $stable(aux_out));

   // R9: reset empties the outputs whatever the enable does
   a_r9_reset_clears: assert property (@(posedge clk) disable iff (!armed)
      rst |=> (x_out == '0) && (y_out == '0) && !aux_out);
endmodule

bind cordic_rotator cordic_rot_checker #(
   .OW(OW), .WW(WW), .PW(PW), .NSTAGES(NSTAGES)
) u_chk (
   .clk(clk), .rst(rst), .ce(ce),
   .aux_in(aux_in), .aux_first(aux_sr[0]), .aux_out(aux_out),
   .x_out(x_out), .y_out(y_out), .stage_ph(pp)
);

// File: tb/cordic_rotator_bench.sv
`timescale 1ns/1ps
module cordic_rotator_bench;
   localparam int  IW = 12, OW = 14, WW = 20, PW = 20, PWB = 16, NST = 16;
   localparam int  LAT = NST + 2;
   localparam int  MAXS = 4096;
   localparam real TWO_PI = 6.283185307179586;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic                 rst, ce, aux_in;
   logic signed [IW-1:0] x_in, y_in;
   logic [PW-1:0]        ph;
   logic signed [OW-1:0] xa, ya, xb, yb;
   logic                 auxa, auxb;

   cordic_rotator #(.IW(IW), .OW(OW), .WW(WW), .PW(PW), .NSTAGES(NST)) u_cordic_rotator (
      .clk(clk), .rst(rst), .ce(ce), .x_in(x_in), .y_in(y_in), .phase_in(ph),
      .aux_in(aux_in), .x_out(xa), .y_out(ya), .aux_out(auxa));

   cordic_rotator #(.IW(IW), .OW(OW), .WW(WW), .PW(PWB), .NSTAGES(NST)) u_cordic_rotator_b (
      .clk(clk), .rst(rst), .ce(ce), .x_in(x_in), .y_in(y_in), .phase_in(ph[PW-1 -: PWB]),
      .aux_in(aux_in), .x_out(xb), .y_out(yb), .aux_out(auxb));

   int n_chk = 0, n_fail = 0;
   int sx [MAXS];
   int sy [MAXS];
   int sp [MAXS];
   int n_stim = 0;
   real ga, gb;

   function automatic int rnd(real v);
      if (v >= 0.0) return $rtoi(v + 0.5);
      return -$rtoi(-v + 0.5);
   endfunction

   function automatic real chain_gain(int pw);
      real g = 1.0;
      for (int n = 1; n <= NST; n++) begin
         real a = (2.0 ** pw) * $atan(2.0 ** (-n)) / TWO_PI;
         if (n < WW && rnd(a) != 0) g = g * $sqrt(1.0 + 2.0 ** (-2 * n));
      end
      return g;
   endfunction

   task automatic chk_eq(string tag, int got, int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic chk_near(string tag, int got, real exp, real tol);
      n_chk++;
      if ((got - exp) > tol || (exp - got) > tol) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %f", tag, got, exp);
      end
   endtask

   task automatic chk_sample_a(int i);
      real t, ex, ey;
      t  = TWO_PI * sp[i] / (2.0 ** PW);
      ex = ga * (sx[i] * $cos(t) - sy[i] * $sin(t));
      ey = ga * (sx[i] * $sin(t) + sy[i] * $cos(t));
      chk_near("R1 R2 R3 R4 R6 x", int'(xa), ex, 1.5);
      chk_near("R1 R2 R3 R4 R6 y", int'(ya), ey, 1.5);
   endtask

   task automatic chk_sample_b(int i);
      real t, ex, ey;
      t  = TWO_PI * (sp[i] >> (PW - PWB)) / (2.0 ** PWB);
      ex = gb * (sx[i] * $cos(t) - sy[i] * $sin(t));
      ey = gb * (sx[i] * $sin(t) + sy[i] * $cos(t));
      chk_near("R5 x", int'(xb), ex, 4.0);
      chk_near("R5 y", int'(yb), ey, 4.0);
   endtask

   task automatic add_stim(int x, int y, int p);
      sx[n_stim] = x;
      sy[n_stim] = y;
      sp[n_stim] = p & ((1 << PW) - 1);
      n_stim++;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int vx [9] = '{2047, 0, -2048, 1448, -2048, 2047, 1, 0, -700};
      int vy [9] = '{0, 2047, 0, 1448, -2048, -2048, 0, 0, 1500};
      logic [31:0] lfsr = 32'hACE1_2357;
      int idx = 0, out_a = 0, out_b = 0, cyc = 0;
      bit prev_ce = 1'b1;
      int hxa = 0, hya = 0, hxb = 0, hyb = 0;
      bit hauxa = 1'b0;
      int wait_n;
      bit seen;

      ga = chain_gain(PW);
      gb = chain_gain(PWB);

      for (int v = 0; v < 9; v++)
         for (int j = 0; j < 256; j++)
            add_stim(vx[v], vy[v], (j << (PW - 8)) + j * 37);
      for (int o = 0; o < 8; o++)
         for (int d = -1; d <= 1; d++)
            add_stim(1500, -700, (o << (PW - 3)) + d);
      for (int r = 0; r < 150; r++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         add_stim($signed(lfsr[31:20]), $signed(lfsr[11:0]), int'(lfsr[19:0] ^ lfsr[31:12]));
      end

      // Reset state (R9)
      rst = 1'b1; ce = 1'b1; aux_in = 1'b0; x_in = '0; y_in = '0; ph = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk_eq("R9 reset x_out", int'(xa), 0);
      chk_eq("R9 reset y_out", int'(ya), 0);
      chk_eq("R9 reset aux_out", int'(auxa), 0);

      // Streaming sweep with stalls (R8) and unmarked gaps (R7)
      while ((out_a < n_stim || out_b < n_stim) && cyc < 20000) begin
         @(negedge clk);
         if (prev_ce) begin
            if (auxa) begin chk_sample_a(out_a); out_a++; end
            if (auxb) begin chk_sample_b(out_b); out_b++; end
         end else begin
            chk_eq("R8 hold x_out", int'(xa), hxa);
            chk_eq("R8 hold y_out", int'(ya), hya);
            chk_eq("R8 hold x_out b", int'(xb), hxb);
            chk_eq("R8 hold y_out b", int'(yb), hyb);
            chk_eq("R8 hold aux_out", int'(auxa), int'(hauxa));
         end
         hxa = xa; hya = ya; hxb = xb; hyb = yb; hauxa = auxa;
         cyc++;
         ce = (cyc % 7 != 3);
         if (idx < n_stim && (cyc % 11 != 5)) begin
            x_in = sx[idx]; y_in = sy[idx]; ph = sp[idx][PW-1:0]; aux_in = 1'b1;
            if (ce) idx++;
         end else begin
            x_in = -12'sd5; y_in = 12'sd77; ph = 20'h5A5A5; aux_in = 1'b0;
         end
         prev_ce = ce;
      end
      chk_eq("R7 marked outputs count", out_a, n_stim);
      chk_eq("R7 marked outputs count b", out_b, n_stim);

      // Latency of a single marker (R7)
      ce = 1'b1; aux_in = 1'b0;
      repeat (LAT + 2) @(negedge clk);
      x_in = 12'sd1000; y_in = 12'sd0; ph = 20'h08000; aux_in = 1'b1;
      @(negedge clk);
      aux_in = 1'b0;
      wait_n = 1; seen = 1'b0;
      while (!seen && wait_n < 3 * LAT) begin
         if (auxa) seen = 1'b1;
         else begin @(negedge clk); wait_n++; end
      end
      chk_eq("R7 latency", wait_n, LAT);

      // Reset while stalled with a full pipeline (R9)
      for (int i = 0; i < LAT + 2; i++) begin
         x_in = 12'sd2000; y_in = 12'sd300; ph = 20'(i * 4099); aux_in = 1'b1;
         @(negedge clk);
      end
      chk_eq("R9 pipeline busy before reset", int'(auxa), 1);
      ce = 1'b0; rst = 1'b1;
      @(negedge clk);
      chk_eq("R9 reset under stall x_out", int'(xa), 0);
      chk_eq("R9 reset under stall y_out", int'(ya), 0);
      chk_eq("R9 reset under stall aux_out", int'(auxa), 0);
      rst = 1'b0; ce = 1'b1; aux_in = 1'b0;
      seen = 1'b0;
      for (int i = 0; i < LAT + 2; i++) begin
         @(negedge clk);
         if (auxa || auxb) seen = 1'b1;
      end
      chk_eq("R9 delay line emptied", int'(seen), 0);

      finish_run();
   end
endmodule